// File: doc/BRIEF.md
# Sixteen-Bit ALU with Gated Status Flags

This block is the arithmetic and logic unit of a small 16-bit microcontroller core. It is purely combinational. Each cycle the core hands it a source operand, a destination operand, a four-bit operation code, a byte/word select and the current carry flag.

The block returns three things:
- the computed value;
- a strobe saying whether that value should be written back;
- the four status flags C, Z, N and V, each with its own write enable. An operation that must leave a flag untouched drops that enable, and the register file keeps the old value.

Subtraction runs through the same adder as addition: the source is inverted and the carry-in is forced to one or taken from the carry flag. Packed decimal addition uses a chain of per-nibble correctors. In byte mode the sign, zero and carry points move from bit 15 down to bit 7.

Top module: `alu16_flags`

## Requirements
- R1: ADD (code 0) gives src + dst and ADDC (code 1) gives src + dst + carryIn. C is the carry out of the top bit of the active width.
- R2: SUB (code 2) gives dst + ~src + 1 and SUBC (code 3) gives dst + ~src + carryIn. C is therefore high when no borrow occurred, which for SUB means dst >= src (unsigned).
- R3: For codes 0 to 4, V is high exactly when the signed sum of dst, the (possibly inverted) source and the carry-in falls outside the signed range of the active width. All four flags are written.
- R4: CMP (code 4) produces the flags and the value of SUB with resultWe low. BIT (code 7) produces the flags and the value of AND with resultWe low.
- R5: DADD (code 5) adds src, dst and carryIn digit by digit from the low nibble upward. A nibble sum above 9 has 6 added to it and passes a carry to the next digit. C is the carry out of the top digit. C, Z and N are written and V is not.
- R6: AND (code 6), BIT (code 7) and XOR (code 10) set C to the inverse of Z. V is cleared, except that XOR sets V when both operands have their sign bit set.
- R7: BIC (code 8) gives ~src & dst, BIS (code 9) gives src | dst and MOV (code 11) gives src. None of them writes any flag.
- R8: RRC (code 12) shifts dst right with carryIn entering the top bit. RRA (code 13) shifts dst right keeping the top bit. Both put bit 0 into C, clear V and write all flags.
- R9: SWPB (code 14) exchanges the two bytes of dst, ignores byteOp and writes no flag.
- R10: SXT (code 15) copies bit 7 of dst into bits 15..8 whatever byteOp says. It writes N and Z, sets C to the inverse of Z and clears V.
- R11: With byteOp high, every code except 14 and 15 works on bits 7..0. N is bit 7, Z looks at the low byte, C comes from bit 7, and result[15:8] is zero.
- R12: For every flag-writing code, N is the top bit of the active width and Z is high exactly when the active-width result is zero. resultWe is high for every code except 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcIn | input | 16 | Source operand |
| dstIn | input | 16 | Destination operand |
| opSel | input | 4 | Operation code |
| byteOp | input | 1 | High selects an 8-bit operation |
| carryIn | input | 1 | Current carry flag |
| result | output | 16 | Computed value |
| resultWe | output | 1 | Result should be written back |
| cFlag | output | 1 | Carry flag value |
| zFlag | output | 1 | Zero flag value |
| nFlag | output | 1 | Negative flag value |
| vFlag | output | 1 | Overflow flag value |
| cWe | output | 1 | Carry flag write enable |
| zWe | output | 1 | Zero flag write enable |
| nWe | output | 1 | Negative flag write enable |
| vWe | output | 1 | Overflow flag write enable |

## Verification
The block holds no state, so a fault shows up on the same evaluation as the operand pattern that provokes it. Faults include a wrong carry-in choice, a dropped source inversion, a misplaced byte-mode sign point or a missing decimal correction. Each appears as a wrong result, flag or enable on that evaluation, and nothing masks it later. A sweep over every code, both widths, both carry values and a grid of operands catches each fault at the first vector that sensitises it. The grid includes sign boundaries, all-ones, zero and decimal patterns.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,  OP_DADD = 4'd5,  OP_AND  = 4'd6,  OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,  OP_BIS  = 4'd9,  OP_XOR  = 4'd10, OP_MOV  = 4'd11,
    OP_RRC  = 4'd12, OP_RRA  = 4'd13, OP_SWPB = 4'd14, OP_SXT  = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    U_ADD, U_DEC, U_LOGIC, U_SHIFT, U_SWAP, U_SEXT, U_PASS
  } unit_e;

  typedef enum logic [1:0] {L_AND, L_OR, L_XOR, L_ANDN} logicOp_e;

  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_FLAG} carrySel_e;

  typedef enum logic [1:0] {V_ZERO, V_ARITH, V_BOTHNEG} vSel_e;

  // strobes steering the datapath
  typedef struct packed {
    unit_e     unit;
    logicOp_e  lop;
    carrySel_e cin;
    logic      invSrc;
    logic      arithShift;
    logic      forceWord;
    logic      cFromZ;
    vSel_e     vSel;
  } dpCtrl_t;

  // strobes leaving the block as write enables
  typedef struct packed {
    logic wrRes;
    logic weC;
    logic weZ;
    logic weN;
    logic weV;
  } wrCtrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [3:0] opSel,
  output dpCtrl_t    dpCtrl,
  output wrCtrl_t    wrCtrl
);

  always_comb begin
    dpCtrl.unit       = U_PASS;
    dpCtrl.lop        = L_AND;
    dpCtrl.cin        = CI_ZERO;
    dpCtrl.invSrc     = 1'b0;
    dpCtrl.arithShift = 1'b0;
    dpCtrl.forceWord  = 1'b0;
    dpCtrl.cFromZ     = 1'b0;
    dpCtrl.vSel       = V_ZERO;
    wrCtrl.wrRes      = 1'b1;
    wrCtrl.weC        = 1'b1;
    wrCtrl.weZ        = 1'b1;
    wrCtrl.weN        = 1'b1;
    wrCtrl.weV        = 1'b1;

    case (opSel)
      OP_ADD: begin
        dpCtrl.unit = U_ADD;
        dpCtrl.vSel = V_ARITH;
      end
      OP_ADDC: begin
        dpCtrl.unit = U_ADD;
        dpCtrl.cin  = CI_FLAG;
        dpCtrl.vSel = V_ARITH;
      end
      OP_SUB, OP_CMP: begin
        dpCtrl.unit   = U_ADD;
        dpCtrl.cin    = CI_ONE;
        dpCtrl.invSrc = 1'b1;
        dpCtrl.vSel   = V_ARITH;
        wrCtrl.wrRes  = (opSel != OP_CMP);
      end
      OP_SUBC: begin
        dpCtrl.unit   = U_ADD;
        dpCtrl.cin    = CI_FLAG;
        dpCtrl.invSrc = 1'b1;
        dpCtrl.vSel   = V_ARITH;
      end
      OP_DADD: begin
        dpCtrl.unit = U_DEC;
        dpCtrl.cin  = CI_FLAG;
        wrCtrl.weV  = 1'b0;
      end
      OP_AND, OP_BIT: begin
        dpCtrl.unit   = U_LOGIC;
        dpCtrl.lop    = L_AND;
        dpCtrl.cFromZ = 1'b1;
        wrCtrl.wrRes  = (opSel != OP_BIT);
      end
      OP_XOR: begin
        dpCtrl.unit   = U_LOGIC;
        dpCtrl.lop    = L_XOR;
        dpCtrl.cFromZ = 1'b1;
        dpCtrl.vSel   = V_BOTHNEG;
      end
      OP_BIC, OP_BIS: begin
        dpCtrl.unit = U_LOGIC;
        dpCtrl.lop  = (opSel == OP_BIC) ? L_ANDN : L_OR;
        wrCtrl.weC  = 1'b0;
        wrCtrl.weZ  = 1'b0;
        wrCtrl.weN  = 1'b0;
        wrCtrl.weV  = 1'b0;
      end
      OP_MOV: begin
        dpCtrl.unit = U_PASS;
        wrCtrl.weC  = 1'b0;
        wrCtrl.weZ  = 1'b0;
        wrCtrl.weN  = 1'b0;
        wrCtrl.weV  = 1'b0;
      end
      OP_RRC, OP_RRA: begin
        dpCtrl.unit       = U_SHIFT;
        dpCtrl.arithShift = (opSel == OP_RRA);
      end
      OP_SWPB: begin
        dpCtrl.unit      = U_SWAP;
        dpCtrl.forceWord = 1'b1;
        wrCtrl.weC       = 1'b0;
        wrCtrl.weZ       = 1'b0;
        wrCtrl.weN       = 1'b0;
        wrCtrl.weV       = 1'b0;
      end
      default: begin
        dpCtrl.unit      = U_SEXT;
        dpCtrl.forceWord = 1'b1;
        dpCtrl.cFromZ    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  input  logic             byteOp,
  input  logic             carryIn,
  input  dpCtrl_t          ctrl,
  output logic [WIDTH-1:0] res,
  output logic             cOut,
  output logic             zOut,
  output logic             nOut,
  output logic             vOut
);

  localparam int HALF   = WIDTH / 2;
  localparam int NIBS   = WIDTH / 4;
  localparam int HNIBS  = NIBS / 2;

  logic             useByte;
  logic [WIDTH-1:0] bOp;
  logic             ci;

  assign useByte = byteOp & ~ctrl.forceWord;
  assign bOp     = ctrl.invSrc ? ~src : src;

  always_comb begin
    case (ctrl.cin)
      CI_ONE:  ci = 1'b1;
      CI_FLAG: ci = carryIn;
      default: ci = 1'b0;
    endcase
  end

  // binary adder, both widths
  logic [WIDTH:0] sumWord;
  logic [HALF:0]  sumByte;
  logic           addCarry;

  assign sumWord  = {1'b0, dst} + {1'b0, bOp} + {{WIDTH{1'b0}}, ci};
  assign sumByte  = {1'b0, dst[HALF-1:0]} + {1'b0, bOp[HALF-1:0]}
                  + {{HALF{1'b0}}, ci};
  assign addCarry = useByte ? sumByte[HALF] : sumWord[WIDTH];

  // decimal adder: one corrector per nibble, carry rippling upward
  logic [NIBS:0]    decCy;
  logic [WIDTH-1:0] decRes;
  logic             decCarry;

  assign decCy[0] = ci;

  for (genvar g = 0; g < NIBS; g++) begin : g_digit
    logic [4:0] digitSum;
    assign digitSum     = {1'b0, dst[4*g +: 4]} + {1'b0, src[4*g +: 4]}
                        + {4'd0, decCy[g]};
    assign decCy[g+1]   = (digitSum > 5'd9);
    assign decRes[4*g +: 4] = decCy[g+1] ? (digitSum[3:0] + 4'd6)
                                         : digitSum[3:0];
  end

  assign decCarry = useByte ? decCy[HNIBS] : decCy[NIBS];

  // bitwise unit
  logic [WIDTH-1:0] logicRes;

  always_comb begin
    case (ctrl.lop)
      L_OR:    logicRes = src | dst;
      L_XOR:   logicRes = src ^ dst;
      L_ANDN:  logicRes = ~src & dst;
      default: logicRes = src & dst;
    endcase
  end

  // right shifter
  logic [WIDTH-1:0] shiftRes;
  logic             fillByte;
  logic             fillWord;

  assign fillByte = ctrl.arithShift ? dst[HALF-1]  : carryIn;
  assign fillWord = ctrl.arithShift ? dst[WIDTH-1] : carryIn;

  always_comb begin
    if (useByte)
      shiftRes = {{HALF{1'b0}}, fillByte, dst[HALF-1:1]};
    else
      shiftRes = {fillWord, dst[WIDTH-1:1]};
  end

  // byte swap and sign extension
  logic [WIDTH-1:0] swapRes;
  logic [WIDTH-1:0] sextRes;

  assign swapRes = {dst[HALF-1:0], dst[WIDTH-1:HALF]};
  assign sextRes = {{HALF{dst[HALF-1]}}, dst[HALF-1:0]};

  // result select and width mask
  logic [WIDTH-1:0] rawRes;

  always_comb begin
    case (ctrl.unit)
      U_ADD:   rawRes = sumWord[WIDTH-1:0];
      U_DEC:   rawRes = decRes;
      U_LOGIC: rawRes = logicRes;
      U_SHIFT: rawRes = shiftRes;
      U_SWAP:  rawRes = swapRes;
      U_SEXT:  rawRes = sextRes;
      default: rawRes = src;
    endcase
  end

  assign res = useByte ? {{HALF{1'b0}}, rawRes[HALF-1:0]} : rawRes;

  // flags
  logic aMsb;
  logic bMsb;
  logic srcMsb;

  assign aMsb   = useByte ? dst[HALF-1] : dst[WIDTH-1];
  assign bMsb   = useByte ? bOp[HALF-1] : bOp[WIDTH-1];
  assign srcMsb = useByte ? src[HALF-1] : src[WIDTH-1];

  assign zOut = useByte ? (res[HALF-1:0] == '0) : (res == '0);
  assign nOut = useByte ? res[HALF-1] : res[WIDTH-1];

  always_comb begin
    if (ctrl.cFromZ)
      cOut = ~zOut;
    else begin
      case (ctrl.unit)
        U_ADD:   cOut = addCarry;
        U_DEC:   cOut = decCarry;
        U_SHIFT: cOut = dst[0];
        default: cOut = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (ctrl.vSel)
      V_ARITH:   vOut = (aMsb == bMsb) && (nOut != aMsb);
      V_BOTHNEG: vOut = srcMsb & aMsb;
      default:   vOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
(
  input  logic [15:0] srcIn,
  input  logic [15:0] dstIn,
  input  logic [3:0]  opSel,
  input  logic        byteOp,
  input  logic        carryIn,
  output logic [15:0] result,
  output logic        resultWe,
  output logic        cFlag,
  output logic        zFlag,
  output logic        nFlag,
  output logic        vFlag,
  output logic        cWe,
  output logic        zWe,
  output logic        nWe,
  output logic        vWe
);

  dpCtrl_t dpCtrl;
  wrCtrl_t wrCtrl;

  alu16_ctrl u_ctrl (
    .opSel  (opSel),
    .dpCtrl (dpCtrl),
    .wrCtrl (wrCtrl)
  );

  alu16_datapath #(.WIDTH(16)) u_dp (
    .src     (srcIn),
    .dst     (dstIn),
    .byteOp  (byteOp),
    .carryIn (carryIn),
    .ctrl    (dpCtrl),
    .res     (result),
    .cOut    (cFlag),
    .zOut    (zFlag),
    .nOut    (nFlag),
    .vOut    (vFlag)
  );

  assign resultWe = wrCtrl.wrRes;
  assign cWe      = wrCtrl.weC;
  assign zWe      = wrCtrl.weZ;
  assign nWe      = wrCtrl.weN;
  assign vWe      = wrCtrl.weV;

endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk (
  input logic [15:0] srcIn,
  input logic [15:0] dstIn,
  input logic [3:0]  opSel,
  input logic        byteOp,
  input logic [15:0] result,
  input logic        resultWe,
  input logic        cFlag,
  input logic        zFlag,
  input logic        cWe,
  input logic        zWe,
  input logic        nWe,
  input logic        vWe
);

  always_comb begin
    if (!byteOp && opSel == 4'd0)
      p_add_carry_r1: assert ({cFlag, result} == ({1'b0, srcIn} + {1'b0, dstIn}))
        else $error("add carry/sum mismatch");
    if (!byteOp && opSel == 4'd2)
      p_sub_noborrow_r2: assert (cFlag == (dstIn >= srcIn))
        else $error("sub carry is not the inverted borrow");
    if (opSel == 4'd4 || opSel == 4'd7)
      p_no_writeback_r4: assert (!resultWe)
        else $error("compare/test wrote a result");
    if (opSel == 4'd6 || opSel == 4'd7 || opSel == 4'd10)
      p_logic_carry_r6: assert (cFlag == !zFlag)
        else $error("logic op carry is not inverse zero");
    if (opSel == 4'd14)
      p_swap_quiet_r9: assert (!cWe && !zWe && !nWe && !vWe &&
                               result == {dstIn[7:0], dstIn[15:8]})
        else $error("byte swap wrong or touched flags");
    if (byteOp && opSel != 4'd14 && opSel != 4'd15)
      p_byte_upper_r11: assert (result[15:8] == 8'h00)
        else $error("byte op left upper byte set");
  end

endmodule

bind alu16_flags alu16_flags_chk u_chk (
  .srcIn    (srcIn),
  .dstIn    (dstIn),
  .opSel    (opSel),
  .byteOp   (byteOp),
  .result   (result),
  .resultWe (resultWe),
  .cFlag    (cFlag),
  .zFlag    (zFlag),
  .cWe      (cWe),
  .zWe      (zWe),
  .nWe      (nWe),
  .vWe      (vWe)
);

// File: tb/tb_alu16_flags.sv
`timescale 1ns/1ps
module tb_alu16_flags;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] srcIn = '0;
  logic [15:0] dstIn = '0;
  logic [3:0]  opSel = '0;
  logic        byteOp = 1'b0;
  logic        carryIn = 1'b0;
  logic [15:0] result;
  logic        resultWe, cFlag, zFlag, nFlag, vFlag, cWe, zWe, nWe, vWe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu16_flags dut (
    .srcIn(srcIn), .dstIn(dstIn), .opSel(opSel), .byteOp(byteOp),
    .carryIn(carryIn), .result(result), .resultWe(resultWe),
    .cFlag(cFlag), .zFlag(zFlag), .nFlag(nFlag), .vFlag(vFlag),
    .cWe(cWe), .zWe(zWe), .nWe(nWe), .vWe(vWe)
  );

  function automatic logic [15:0] operand(int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h007F;
      3: return 16'h0080;  4: return 16'h00FF;  5: return 16'h0100;
      6: return 16'h7FFF;  7: return 16'h8000;  8: return 16'hFFFF;
      9: return 16'h0999;  10: return 16'h9999; 11: return 16'h5555;
      12: return 16'hAAAA; 13: return 16'h8080; 14: return 16'h0009;
      15: return 16'h4950;
      default: return 16'((k * 40503 + 12345) ^ (k << 9));
    endcase
  endfunction

  function automatic string reqOf(int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 7: return "R4";
      5: return "R5";
      6, 10: return "R6";
      8, 9, 11: return "R7";
      12, 13: return "R8";
      14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s op=%0d byte=%0b cin=%0b src=%h dst=%h: got %h expected %h",
               req, what, opSel, byteOp, carryIn, srcIn, dstIn, got, exp);
    end
  endtask

  task automatic runVector(int op, bit bm, bit ci, logic [15:0] s16, logic [15:0] d16);
    int w, mask, msb, d, s, b, cin, full, r, sd, sb, ss, cy, t;
    bit eC, eV, weC, weZ, weN, weV, wr;
    string rq;
    opSel = 4'(op); byteOp = bm; carryIn = ci; srcIn = s16; dstIn = d16;
    @(negedge clk);
    w    = (bm && op != 14 && op != 15) ? 8 : 16;
    mask = (1 << w) - 1;
    msb  = 1 << (w - 1);
    d    = int'(d16) & mask;
    s    = int'(s16) & mask;
    eC = 0; eV = 0; r = 0;
    weC = 1; weZ = 1; weN = 1; weV = 1; wr = 1;
    case (op)
      0, 1, 2, 3, 4: begin
        b   = (op >= 2) ? (~int'(s16) & mask) : s;
        cin = (op == 0) ? 0 : (op == 2 || op == 4) ? 1 : int'(ci);
        full = d + b + cin;
        r  = full & mask;
        eC = ((full >> w) & 1) != 0;
        sd = (d & msb) ? d - (1 << w) : d;
        sb = (b & msb) ? b - (1 << w) : b;
        ss = sd + sb + cin;
        eV = (ss > msb - 1) || (ss < -msb);
        wr = (op != 4);
      end
      5: begin
        cy = int'(ci);
        for (int k = 0; k < w / 4; k++) begin
          t = ((d >> (4 * k)) & 15) + ((s >> (4 * k)) & 15) + cy;
          if (t > 9) begin t = t + 6; cy = 1; end else cy = 0;
          r = r | ((t & 15) << (4 * k));
        end
        eC = (cy != 0);
        weV = 0;
      end
      6, 7: begin r = d & s; eC = (r != 0); wr = (op == 6); end
      10: begin r = d ^ s; eC = (r != 0); eV = ((d & msb) != 0) && ((s & msb) != 0); end
      8, 9, 11: begin
        r = (op == 8) ? (~s & d & mask) : (op == 9) ? (s | d) : s;
        weC = 0; weZ = 0; weN = 0; weV = 0;
      end
      12, 13: begin
        r  = (d >> 1) | ((op == 12) ? (ci ? msb : 0) : (d & msb));
        eC = (d & 1) != 0;
      end
      14: begin
        r = ((d & 255) << 8) | (d >> 8);
        weC = 0; weZ = 0; weN = 0; weV = 0;
      end
      default: begin
        r  = (d & 128) ? ((d & 255) | 16'hFF00) : (d & 255);
        eC = (r != 0);
      end
    endcase
    rq = reqOf(op);
    chk(rq, "result", int'(result), r);
    chk("R12", "resultWe", int'(resultWe), int'(wr));
    chk(rq, "cWe", int'(cWe), int'(weC));
    chk(rq, "zWe", int'(zWe), int'(weZ));
    chk(rq, "nWe", int'(nWe), int'(weN));
    chk(rq, "vWe", int'(vWe), int'(weV));
    if (weC) chk(rq, "C", int'(cFlag), int'(eC));
    if (weV) chk((op <= 4) ? "R3" : rq, "V", int'(vFlag), int'(eV));
    if (weZ) chk("R12", "Z", int'(zFlag), int'(r == 0));
    if (weN) chk(w == 8 ? "R11" : "R12", "N", int'(nFlag), int'((r & msb) != 0));
    if (bm && op != 14 && op != 15) chk("R11", "upper byte", int'(result[15:8]), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // idle inputs: ADD of zeros
    chk("R12", "idle result", int'(result), 0);
    chk("R12", "idle Z", int'(zFlag), 1);
    // directed decimal case: 0x0999 + 0x0001 -> 0x1000, no carry (R5)
    runVector(5, 1'b0, 1'b0, 16'h0001, 16'h0999);
    chk("R5", "decimal ripple", int'(result), 16'h1000);
    for (int op = 0; op < 16; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
              runVector(op, bm[0], ci[0], operand(i), operand(j));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule